// File: doc/BRIEF.md
# Key-Unlocked Shadow Configuration Register Bank

This block holds a small bank of configuration registers, each of which copies a non-volatile default. The defaults arrive as a static input vector. While reset is held, every register takes its default. The control outputs of the block always come from these working copies and never from the default vector, so a change on the default inputs after reset has no effect until the next reset.

A host writes through a simple port: an address, a data byte and a one-cycle strobe. Registers marked as protected change only when the write directly follows the key byte 0x35 at the shadow-control address 0x3A. That pending permission is used up by the next write, whatever its address or value. A value written this way stays in place until the next reset. A combinational read port returns the working copy of any register, whatever the lock state.

Top module: `shadow_cfg_regs`

## Requirements
- R1: While rst_n is low, register slot i (address 0x40+i) loads otp_defaults[8*i+7:8*i]. After reset the shadow-control byte at 0x3A reads 0x00 and the block is locked.
- R2: cfg_out[8*i+7:8*i] always equals the value read back from address 0x40+i. A change on otp_defaults after reset has no effect on either.
- R3: A write to protected address 0x40 that is the first write after a write of 0x35 to 0x3A updates that register at the next clock edge. Writing the key again before the protected write leaves the permission in place.
- R4: A write to 0x40 while locked leaves the register unchanged.
- R5: A write to any address other than 0x3A, made between the key write and the protected write, cancels the permission, so the protected write is then ignored.
- R6: The permission serves one protected write only, even when that write keeps the same value. The next protected write is ignored.
- R7: Writing any value other than 0x35 to 0x3A leaves the block locked, or locks it again.
- R8: Unprotected slots (0x41 to 0x43) take writes at any time, with no key.
- R9: Reads have no effect on the lock state. Address 0x3A reads the last byte written there, and an address outside the bank and the control register reads 0x00.
- R10: Cycles with wr_en low between the key write and the protected write do not cancel the permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads the defaults |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Combinational readback of the addressed working copy |
| otp_defaults | input | 32 | Non-volatile defaults, one byte per slot, slot 0 in the low byte |
| cfg_out | output | 32 | Working copies driving internal logic, slot 0 in the low byte |

## Verification
The bench goes after the ways the permission can leak. A design that arms on any control write lets the wrong key through. A design that keeps the permission after use accepts a second protected write. A design that ignores intervening writes to other slots accepts a protected write after a cancelling write. A design that counts idle cycles as writes rejects a slow but legal sequence. The bench also changes the default bus after reset, so a design that feeds cfg_out from the defaults shows the new value. A second reset checks that shadow writes last only until reset.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;
   typedef enum logic {
      LOCK_CLOSED = 1'b0,
      LOCK_ARMED  = 1'b1
   } lock_state_e;

   function automatic bit slot_is_protected(input int unsigned mask, input int idx);
      return ((mask >> idx) & 1) == 1;
   endfunction
endpackage

// File: rtl/shadow_key_fsm.sv
module shadow_key_fsm
   import shadow_cfg_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 'h3A,
   parameter int KEY       = 'h35
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              armed
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [DATA_W-1:0] KEY_V  = DATA_W'(KEY);

   lock_state_e state_q, state_d;

   // Every write decides the next state; idle cycles hold it.
   always_comb begin
      state_d = state_q;
      if (wr_en) begin
         if (wr_addr == CTRL_A && wr_data == KEY_V) state_d = LOCK_ARMED;
         else                                       state_d = LOCK_CLOSED;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LOCK_CLOSED;
      else        state_q <= state_d;
   end

   assign armed = (state_q == LOCK_ARMED);
endmodule

// File: rtl/shadow_reg_slot.sv
module shadow_reg_slot #(
   parameter int DATA_W    = 8,
   parameter bit PROTECTED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] load_val,
   input  logic              wr_hit,
   input  logic              armed,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q
);
   logic wr_ok;

   generate
      if (PROTECTED) begin : g_gated
         assign wr_ok = wr_hit & armed;
      end else begin : g_open
         assign wr_ok = wr_hit;
         logic unused_armed;
         assign unused_armed = armed;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= load_val;
      else if (wr_ok) q <= wr_data;
   end
endmodule

// File: rtl/shadow_rd_mux.sv
module shadow_rd_mux #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int NUM_REGS  = 4,
   parameter int BASE_ADDR = 'h40,
   parameter int CTRL_ADDR = 'h3A
) (
   input  logic [ADDR_W-1:0]          rd_addr,
   input  logic [NUM_REGS*DATA_W-1:0] bank,
   input  logic [DATA_W-1:0]          ctrl_q,
   output logic [DATA_W-1:0]          rd_data
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   always_comb begin
      rd_data = '0;
      if (rd_addr == CTRL_A) rd_data = ctrl_q;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == ADDR_W'(BASE_ADDR + i)) rd_data = bank[i*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
   import shadow_cfg_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 8,
   parameter int          NUM_REGS  = 4,
   parameter int          BASE_ADDR = 'h40,
   parameter int          CTRL_ADDR = 'h3A,
   parameter int          KEY       = 'h35,
   parameter int unsigned PROT_MASK = 32'h1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   input  logic [NUM_REGS*DATA_W-1:0] otp_defaults,
   output logic [NUM_REGS*DATA_W-1:0] cfg_out
);
   localparam int               ADDR_SPAN = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_ADDR);

   generate
      if (NUM_REGS < 1 || NUM_REGS > 32) begin : g_bad_count
         $error("NUM_REGS must lie in 1..32");
      end
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_aw
         $error("ADDR_W must lie in 2..16");
      end
      if (BASE_ADDR + NUM_REGS > ADDR_SPAN) begin : g_bad_base
         $error("register bank runs past the address space");
      end
      if (CTRL_ADDR >= BASE_ADDR && CTRL_ADDR < BASE_ADDR + NUM_REGS) begin : g_bad_ctrl
         $error("control address overlaps the bank");
      end
      if (KEY >= (1 << DATA_W)) begin : g_bad_key
         $error("KEY does not fit DATA_W");
      end
   endgenerate

   logic              key_armed;
   logic [DATA_W-1:0] ctrl_q;

   shadow_key_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .KEY(KEY)
   ) u_key (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .armed(key_armed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ctrl_q <= '0;
      else if (wr_en && wr_addr == CTRL_A) ctrl_q <= wr_data;
   end

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
         localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(BASE_ADDR + i);
         shadow_reg_slot #(
            .DATA_W(DATA_W), .PROTECTED(slot_is_protected(PROT_MASK, i))
         ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .load_val(otp_defaults[i*DATA_W +: DATA_W]),
            .wr_hit(wr_en && wr_addr == SLOT_A),
            .armed(key_armed),
            .wr_data(wr_data),
            .q(cfg_out[i*DATA_W +: DATA_W])
         );
      end
   endgenerate

   shadow_rd_mux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
      .BASE_ADDR(BASE_ADDR), .CTRL_ADDR(CTRL_ADDR)
   ) u_rd (
      .rd_addr(rd_addr), .bank(cfg_out), .ctrl_q(ctrl_q), .rd_data(rd_data)
   );
endmodule

// File: rtl/shadow_cfg_regs_chk.sv
module shadow_cfg_regs_chk
   import shadow_cfg_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 8,
   parameter int          NUM_REGS  = 4,
   parameter int          BASE_ADDR = 'h40,
   parameter int          CTRL_ADDR = 'h3A,
   parameter int          KEY       = 'h35,
   parameter int unsigned PROT_MASK = 32'h1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [ADDR_W-1:0]          wr_addr,
   input logic [DATA_W-1:0]          wr_data,
   input logic                       armed,
   input logic [NUM_REGS*DATA_W-1:0] cfg_out
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [DATA_W-1:0] KEY_V  = DATA_W'(KEY);

   AST_KEY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CTRL_A && wr_data == KEY_V) |=> armed); // R3
   AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CTRL_A && wr_data != KEY_V) |=> !armed); // R7
   AST_OTHER_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != CTRL_A) |=> !armed); // R5
   AST_IDLE_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> $stable(armed)); // R10
   AST_IDLE_HOLDS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> $stable(cfg_out)); // R2

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
         localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(BASE_ADDR + i);
         if (slot_is_protected(PROT_MASK, i)) begin : g_prot
            AST_LOCKED_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en && wr_addr == SLOT_A && !armed) |=> $stable(cfg_out[i*DATA_W +: DATA_W])); // R4
            AST_ARMED_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en && wr_addr == SLOT_A && armed) |=> cfg_out[i*DATA_W +: DATA_W] == $past(wr_data)); // R3
         end else begin : g_open
            AST_OPEN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en && wr_addr == SLOT_A) |=> cfg_out[i*DATA_W +: DATA_W] == $past(wr_data)); // R8
         end
      end
   endgenerate
endmodule

bind shadow_cfg_regs shadow_cfg_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR),
   .CTRL_ADDR(CTRL_ADDR), .KEY(KEY), .PROT_MASK(PROT_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .armed(key_armed), .cfg_out(cfg_out)
);

// File: tb/shadow_cfg_regs_bench.sv
module shadow_cfg_regs_bench;
   localparam int NREG = 4;
   localparam logic [7:0] BASE = 8'h40;
   localparam logic [7:0] CTRL = 8'h3A;
   localparam logic [7:0] KEYB = 8'h35;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [7:0]      wr_addr = '0;
   logic [7:0]      wr_data = '0;
   logic [7:0]      rd_addr = '0;
   logic [7:0]      rd_data;
   logic [NREG*8-1:0] otp_defaults = 32'hD493_27A1;
   logic [NREG*8-1:0] cfg_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] model [NREG];
   logic [7:0] ctrl_m;
   bit         armed_m;

   logic [7:0] q_addr [$];
   logic [7:0] q_exp  [$];
   string      q_req  [$];

   always #5 clk = ~clk;

   shadow_cfg_regs u_shadow_cfg_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .otp_defaults(otp_defaults), .cfg_out(cfg_out)
   );

   function automatic bit in_bank(input logic [7:0] a);
      return a >= BASE && a < BASE + NREG;
   endfunction

   task automatic do_reset();
      @(posedge clk); #1 rst_n = 1'b0;
      @(posedge clk); @(posedge clk); #1 rst_n = 1'b1;
      for (int i = 0; i < NREG; i++) model[i] = otp_defaults[i*8 +: 8];
      ctrl_m = '0;
      armed_m = 1'b0;
   endtask

   // Driver: a write, with the expected state updated from the rules.
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #1 wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1 wr_en = 1'b0;
      if (a == CTRL) begin
         ctrl_m = d;
         armed_m = (d == KEYB);
      end else begin
         if (in_bank(a)) begin
            if (a != BASE || armed_m) model[a - BASE] = d;
         end
         armed_m = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
   endtask

   // Driver: a read, pushing the expected value for the monitor.
   task automatic rd(input logic [7:0] a, input string req);
      @(posedge clk); #1 rd_addr = a;
      q_addr.push_back(a);
      q_req.push_back(req);
      if (a == CTRL)      q_exp.push_back(ctrl_m);
      else if (in_bank(a)) q_exp.push_back(model[a - BASE]);
      else                q_exp.push_back(8'h00);
   endtask

   // Monitor: compares at the falling edge, away from the active edge.
   initial begin
      logic [7:0] a, e;
      string r;
      forever begin
         @(negedge clk);
         while (q_addr.size() > 0) begin
            a = q_addr.pop_front();
            e = q_exp.pop_front();
            r = q_req.pop_front();
            checks++;
            if (rd_data !== e) begin
               fails++;
               $display("FAIL %s: read 0x%02h got 0x%02h expected 0x%02h", r, a, rd_data, e);
            end
            if (in_bank(a)) begin
               checks++;
               if (cfg_out[(a - BASE)*8 +: 8] !== e) begin
                  fails++;
                  $display("FAIL R2: cfg_out slot %0d got 0x%02h expected 0x%02h",
                           a - BASE, cfg_out[(a - BASE)*8 +: 8], e);
               end
            end
         end
      end
   end

   initial begin
      do_reset();
      // R1: defaults loaded, control byte cleared
      for (int i = 0; i < NREG; i++) rd(BASE + 8'(i), "R1");
      rd(CTRL, "R1");
      rd(8'h55, "R9");
      // R2: default bus changes after reset have no effect
      otp_defaults = 32'h1122_3344;
      rd(BASE, "R2");
      rd(BASE + 8'd2, "R2");
      // R4: protected write while locked
      wr(BASE, 8'h50);
      rd(BASE, "R4");
      // R3: key then protected write
      wr(CTRL, KEYB); wr(BASE, 8'h50);
      rd(BASE, "R3");
      rd(CTRL, "R9");
      // R6: permission already used
      wr(BASE, 8'h66);
      rd(BASE, "R6");
      // R5 / R8: open slot write in between cancels
      wr(CTRL, KEYB); wr(BASE + 8'd1, 8'h11); wr(BASE, 8'h77);
      rd(BASE + 8'd1, "R8");
      rd(BASE, "R5");
      // R5: write to an unmapped address also cancels
      wr(CTRL, KEYB); wr(8'h20, 8'hEE); wr(BASE, 8'h78);
      rd(BASE, "R5");
      // R7: wrong key
      wr(CTRL, 8'h34); wr(BASE, 8'h77);
      rd(BASE, "R7");
      // R7: wrong key after right key re-locks
      wr(CTRL, KEYB); wr(CTRL, 8'hCA); wr(BASE, 8'h79);
      rd(BASE, "R7");
      // R10: idle cycles keep the permission
      wr(CTRL, KEYB); idle(3); wr(BASE, 8'h3C);
      rd(BASE, "R10");
      // R6: same-value write consumes the permission
      wr(CTRL, KEYB); wr(BASE, 8'h3C); wr(BASE, 8'h99);
      rd(BASE, "R6");
      // R3: repeated key keeps the permission
      wr(CTRL, KEYB); wr(CTRL, KEYB); wr(BASE, 8'h5A);
      rd(BASE, "R3");
      // R9: reads while armed do not disturb the lock
      wr(CTRL, KEYB);
      rd(BASE, "R9"); rd(CTRL, "R9");
      wr(BASE, 8'h12);
      rd(BASE, "R9");
      // R8: open slot without any key
      wr(BASE + 8'd3, 8'hC3);
      rd(BASE + 8'd3, "R8");
      // R1: shadow values last only until reset
      do_reset();
      for (int i = 0; i < NREG; i++) rd(BASE + 8'(i), "R1");
      rd(CTRL, "R1");
      idle(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule